// File: doc/BRIEF.md
# Edge-Select GPIO Port with Interrupt

A 16-pin general-purpose I/O port that sits on a simple 16-bit register bus. Software sets, per pin, whether the pin is driven or sampled, what value it drives, which transition (rising or falling) counts as an event, and whether that event may raise the interrupt. Sampled pins pass through a two-flop synchronizer. A transition of the chosen polarity on an unmasked input pin sets a sticky status bit. The single interrupt line stays high while any status bit is set. Software clears status bits by writing ones to them.

A read of the input-data register returns the synchronized pin levels ANDed with a per-pin read-enable register. The bus accepts only half-word (16-bit) accesses. An access of any other width is dropped on write and reads as zero.

The bus is a plain register port. There is no back-pressure: a write is taken on the clock edge where `bus_en` and `bus_we` are both high. Read data is combinational from `bus_addr` and `bus_size` in the same cycle as `bus_en`. Pins and the interrupt are plain level signals.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, the output-value, direction, polarity, mask and read-enable registers all read 0xFFFF, input data and status read 0x0000, and `irq` is low.
- R2: `pin_oe` equals the inverse of the direction register, so a direction bit of 1 makes the pin an input. `pin_out` equals the output-value register ANDed with `pin_oe`.
- R3: On a pin whose polarity bit is 1, a 0-to-1 change of the synchronized input sets that pin's status bit. A 1-to-0 change does not.
- R4: On a pin whose polarity bit is 0, a 1-to-0 change of the synchronized input sets that pin's status bit. A 0-to-1 change does not.
- R5: A status bit is set only when its direction bit is 1 (input) and its mask bit is 0.
- R6: `irq` is high exactly while the status register is non-zero. It rises in the same cycle that the first status bit becomes visible.
- R7: A half-word write to the status offset (0x14) clears each bit written as 1 and leaves each bit written as 0. `irq` falls only through such a write.
- R8: A read at offset 0x00 returns the synchronized inputs ANDed with the read-enable register (offset 0x18). A pin change becomes visible there after two rising clock edges, and status is set on the third.
- R9: `bus_size` encodes 0 = byte, 1 = half-word, 2 = word, 3 = reserved. Only code 1 is accepted: other writes change nothing, and other reads return 0.
- R10: Writes to offset 0x00 and to any unmapped offset change nothing. Reads of unmapped offsets return 0.
- R11: Offsets 0x04 (output value), 0x08 (direction), 0x0C (polarity), 0x10 (mask) and 0x18 (read-enable) read back the last half-word written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access width code (1 = half-word) |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while `bus_en` is high and `bus_we` is low |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Driven pin values, zero where not enabled |
| pin_oe | output | 16 | Per-pin output enable |
| irq | output | 1 | Interrupt, high while any status bit is set |

## Verification
A wrong value in the direction or output-value register shows on `pin_oe` or `pin_out` on the cycle after the write. A fault in the previous-sample register or the polarity logic appears as a status bit that is set or missing. That status bit can be read back, and `irq` shows it three edges after the pin moves. A status clear that reaches the wrong bits shows on the next read of offset 0x14, or as `irq` staying high or dropping early. Random traffic mixes register writes, status clears and pin toggles. After each step, every readable register and `irq` are compared with a bench model.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // access width codes on bus_size
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } bus_size_e;

  // register byte offsets
  localparam logic [7:0] OFS_IN   = 8'h00;
  localparam logic [7:0] OFS_OUT  = 8'h04;
  localparam logic [7:0] OFS_DIR  = 8'h08;
  localparam logic [7:0] OFS_POL  = 8'h0C;
  localparam logic [7:0] OFS_MASK = 8'h10;
  localparam logic [7:0] OFS_STAT = 8'h14;
  localparam logic [7:0] OFS_REN  = 8'h18;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[LAST];
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] qual,
  output logic [W-1:0] evt
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [W-1:0] prev_q;
  logic [W-1:0] rise;
  logic [W-1:0] fall;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= smp;
  end

  // each pin looks for one transition, picked by its polarity bit
  genvar g;
  for (g = 0; g < W; g++) begin : g_pin
    assign rise[g] = smp[g] & ~prev_q[g];
    assign fall[g] = ~smp[g] & prev_q[g];
    assign evt[g]  = qual[g] & (pol[g] ? rise[g] : fall[g]);
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_edge_pkg::*;
#(
  parameter int W      = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      smp,
  input  logic [W-1:0]      evt,
  output logic [W-1:0]      out_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      mask_q,
  output logic [W-1:0]      stat_q,
  output logic [W-1:0]      ren_q,
  output logic              irq_q
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(OFS_IN);
  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(OFS_OUT);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(OFS_POL);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_REN  = ADDR_W'(OFS_REN);

  logic         size_ok;
  logic         wr_ok;
  logic         rd_ok;
  logic [W-1:0] clr_bits;
  logic [W-1:0] stat_nxt;

  assign size_ok = (bus_size == SZ_HALF);
  assign wr_ok   = bus_en & bus_we & size_ok;
  assign rd_ok   = bus_en & ~bus_we & size_ok;

  assign clr_bits = (wr_ok && bus_addr == A_STAT) ? bus_wdata : '0;
  // a new event wins over a clear that lands in the same cycle
  assign stat_nxt = (stat_q & ~clr_bits) | evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= '1;
      dir_q  <= '1;
      pol_q  <= '1;
      mask_q <= '1;
      ren_q  <= '1;
    end else if (wr_ok) begin
      case (bus_addr)
        A_OUT:   out_q  <= bus_wdata;
        A_DIR:   dir_q  <= bus_wdata;
        A_POL:   pol_q  <= bus_wdata;
        A_MASK:  mask_q <= bus_wdata;
        A_REN:   ren_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_nxt;
      irq_q  <= |stat_nxt;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_ok) begin
      case (bus_addr)
        A_IN:    bus_rdata = smp & ren_q;
        A_OUT:   bus_rdata = out_q;
        A_DIR:   bus_rdata = dir_q;
        A_POL:   bus_rdata = pol_q;
        A_MASK:  bus_rdata = mask_q;
        A_STAT:  bus_rdata = stat_q;
        A_REN:   bus_rdata = ren_q;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
  parameter int WIDTH       = 16,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic              irq
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [WIDTH-1:0] smp;
  logic [WIDTH-1:0] evt;
  logic [WIDTH-1:0] out_q, dir_q, pol_q, mask_q, stat_q, ren_q;
  logic [WIDTH-1:0] qual;

  gpio_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(smp)
  );

  // only unmasked input pins can raise a status bit
  assign qual = dir_q & ~mask_q;

  gpio_edge_detect #(.W(WIDTH)) u_edge (
    .clk(clk), .rst_n(rst_n), .smp(smp), .pol(pol_q), .qual(qual), .evt(evt)
  );

  gpio_regfile #(.W(WIDTH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .smp(smp), .evt(evt),
    .out_q(out_q), .dir_q(dir_q), .pol_q(pol_q), .mask_q(mask_q),
    .stat_q(stat_q), .ren_q(ren_q), .irq_q(irq)
  );

  assign pin_oe  = ~dir_q;
  assign pin_out = out_q & ~dir_q;
endmodule

// File: rtl/gpio_edge_port_checker.sv
module gpio_edge_port_checker
  import gpio_edge_pkg::*;
#(
  parameter int W      = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [1:0]        bus_size,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      bus_rdata,
  input logic [W-1:0]      pin_out,
  input logic [W-1:0]      pin_oe,
  input logic              irq,
  input logic [W-1:0]      stat_q,
  input logic [W-1:0]      mask_q
);
  timeunit 1ns;
  timeprecision 1ps;

  logic hw_wr;
  assign hw_wr = bus_en & bus_we & (bus_size == SZ_HALF);

  p_dir_to_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_wr && bus_addr == ADDR_W'(OFS_DIR)) |=> (pin_oe == ~$past(bus_wdata)));

  p_out_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_wr && bus_addr == ADDR_W'(OFS_OUT)) |=> (pin_out == ($past(bus_wdata) & pin_oe)));

  p_mask_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & $past(mask_q)) == '0));

  p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(hw_wr && bus_addr == ADDR_W'(OFS_STAT)));

  p_bad_width_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_size != SZ_HALF) |=> ($stable(pin_oe) && $stable(pin_out)));

  p_bad_width_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_size != SZ_HALF) |-> (bus_rdata == '0));
endmodule

bind gpio_edge_port gpio_edge_port_checker #(.W(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .stat_q(stat_q), .mask_q(mask_q)
);

// File: tb/gpio_edge_port_test.sv
module gpio_edge_port_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_size = 2'd1;
  logic [7:0]  bus_addr = 8'h00;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic [15:0] pin_in = 16'h0;
  logic [15:0] pin_out;
  logic [15:0] pin_oe;
  logic        irq;

  int checks = 0;
  int failures = 0;

  // bench model of the register state
  logic [15:0] m_out, m_dir, m_pol, m_mask, m_stat, m_ren, m_in;

  always #2 clk = ~clk;  // 250 MHz

  gpio_edge_port uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [7:0] a, input logic [1:0] sz);
    if (sz != 2'd1) return 16'h0;
    case (a)
      8'h00: return m_in & m_ren;
      8'h04: return m_out;
      8'h08: return m_dir;
      8'h0C: return m_pol;
      8'h10: return m_mask;
      8'h14: return m_stat;
      8'h18: return m_ren;
      default: return 16'h0;
    endcase
  endfunction

  task automatic model_reset();
    m_out = '1; m_dir = '1; m_pol = '1; m_mask = '1; m_ren = '1;
    m_stat = '0; m_in = '0;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] sz);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    if (sz == 2'd1) begin
      case (a)
        8'h04: m_out = d;
        8'h08: m_dir = d;
        8'h0C: m_pol = d;
        8'h10: m_mask = d;
        8'h14: m_stat = m_stat & ~d;
        8'h18: m_ren = d;
        default: ;
      endcase
    end
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [1:0] sz, output logic [15:0] v);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = sz;
    #1 v = bus_rdata;
    bus_en = 1'b0;
  endtask

  // model update for a settled pin change
  task automatic model_pins(input logic [15:0] nv);
    logic [15:0] rise, fall;
    rise = nv & ~m_in & m_pol;
    fall = ~nv & m_in & ~m_pol;
    m_stat = m_stat | ((rise | fall) & m_dir & ~m_mask);
    m_in = nv;
  endtask

  task automatic set_pins(input logic [15:0] nv);
    @(negedge clk);
    pin_in = nv;
    repeat (3) @(negedge clk);
    model_pins(nv);
  endtask

  task automatic check_all(input string req);
    logic [15:0] v;
    for (int k = 0; k < 7; k++) begin
      bus_rd(8'(k * 4), 2'd1, v);
      chk(req, v, exp_rd(8'(k * 4), 2'd1));
    end
    chk(req, {15'b0, irq}, {15'b0, |m_stat});
    chk(req, pin_oe, ~m_dir);
    chk(req, pin_out, m_out & ~m_dir);
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog timeout");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int unsigned seed;
    seed = $urandom(32'd4711);
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    bus_rd(8'h04, 2'd1, v); chk("R1 out", v, 16'hFFFF);
    bus_rd(8'h08, 2'd1, v); chk("R1 dir", v, 16'hFFFF);
    bus_rd(8'h0C, 2'd1, v); chk("R1 pol", v, 16'hFFFF);
    bus_rd(8'h10, 2'd1, v); chk("R1 mask", v, 16'hFFFF);
    bus_rd(8'h18, 2'd1, v); chk("R1 ren", v, 16'hFFFF);
    bus_rd(8'h00, 2'd1, v); chk("R1 in", v, 16'h0000);
    bus_rd(8'h14, 2'd1, v); chk("R1 stat", v, 16'h0000);
    chk("R1 irq", {15'b0, irq}, 16'h0);

    // R2: direction and output gating
    bus_wr(8'h08, 16'h00FF, 2'd1);
    bus_wr(8'h04, 16'hA5A5, 2'd1);
    chk("R2 oe", pin_oe, 16'hFF00);
    chk("R2 out", pin_out, 16'hA500);
    bus_wr(8'h08, 16'hFFFF, 2'd1);
    chk("R2 oe all input", pin_oe, 16'h0000);
    chk("R2 out all input", pin_out, 16'h0000);

    // R3: rising on pin0
    bus_wr(8'h10, 16'h0000, 2'd1);
    bus_wr(8'h0C, 16'hFFFD, 2'd1);
    set_pins(16'h0001);
    bus_rd(8'h14, 2'd1, v); chk("R3 rise sets", v, 16'h0001);
    chk("R6 irq up", {15'b0, irq}, 16'h1);
    set_pins(16'h0000);
    bus_rd(8'h14, 2'd1, v); chk("R3 fall ignored", v, 16'h0001);

    // R4: pin1 polarity 0 -> falling only
    set_pins(16'h0002);
    bus_rd(8'h14, 2'd1, v); chk("R4 rise ignored", v, 16'h0001);
    set_pins(16'h0000);
    bus_rd(8'h14, 2'd1, v); chk("R4 fall sets", v, 16'h0003);

    // R7: clear with ones, zeros leave bits
    bus_wr(8'h14, 16'h0001, 2'd1);
    bus_rd(8'h14, 2'd1, v); chk("R7 partial clear", v, 16'h0002);
    chk("R7 irq stays", {15'b0, irq}, 16'h1);
    bus_wr(8'h14, 16'h0000, 2'd1);
    bus_rd(8'h14, 2'd1, v); chk("R7 zero write", v, 16'h0002);
    bus_wr(8'h14, 16'h0002, 2'd1);
    bus_rd(8'h14, 2'd1, v); chk("R7 full clear", v, 16'h0000);
    chk("R6 irq down", {15'b0, irq}, 16'h0);

    // R5: masked pin2, output pin3 do not set status
    bus_wr(8'h10, 16'h0004, 2'd1);
    bus_wr(8'h08, 16'hFFF7, 2'd1);
    set_pins(16'h000C);
    bus_rd(8'h14, 2'd1, v); chk("R5 blocked", v, 16'h0000);
    chk("R5 irq low", {15'b0, irq}, 16'h0);
    set_pins(16'h0000);

    // R8: read enable and latency
    bus_wr(8'h18, 16'h0F0F, 2'd1);
    bus_wr(8'h10, 16'hFFFF, 2'd1);
    @(negedge clk); pin_in = 16'hFFFF;
    bus_rd(8'h00, 2'd1, v); chk("R8 one edge old", v, 16'h0000);
    bus_rd(8'h00, 2'd1, v); chk("R8 two edges new", v, 16'h0F0F);
    repeat (2) @(negedge clk);
    model_pins(16'hFFFF);

    // R9: other widths
    bus_wr(8'h04, 16'h1234, 2'd2);
    bus_wr(8'h08, 16'h0000, 2'd0);
    bus_wr(8'h18, 16'h0000, 2'd3);
    bus_rd(8'h04, 2'd0, v); chk("R9 byte read", v, 16'h0000);
    bus_rd(8'h08, 2'd2, v); chk("R9 word read", v, 16'h0000);
    check_all("R9 regs unchanged");

    // R10: read-only and unmapped
    bus_wr(8'h00, 16'h5555, 2'd1);
    bus_wr(8'h1C, 16'h0000, 2'd1);
    bus_wr(8'h06, 16'h0000, 2'd1);
    bus_rd(8'h1C, 2'd1, v); chk("R10 unmapped", v, 16'h0000);
    bus_rd(8'h02, 2'd1, v); chk("R10 misaligned", v, 16'h0000);
    check_all("R10 regs unchanged");

    // R11 plus mixed random traffic (R3-R8 model)
    for (int it = 0; it < 500; it++) begin
      int op;
      logic [7:0] a;
      logic [1:0] sz;
      op = $urandom_range(0, 2);
      a  = 8'($urandom_range(0, 8) * 4);
      sz = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'd1;
      if (op == 0) begin
        bus_wr(a, 16'($urandom), sz);
      end else if (op == 1) begin
        set_pins(m_in ^ (16'($urandom) & 16'($urandom)));
      end else begin
        bus_rd(a, sz, v);
        chk("R11 random read", v, exp_rd(a, sz));
      end
      chk("R6 random irq", {15'b0, irq}, {15'b0, |m_stat});
    end
    check_all("R11 final");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule